// File: doc/BRIEF.md
# Prioritized Timer Interrupt Vector Generator

This block gathers the interrupt flags of a timer that has seven capture/compare channels, numbered 0 to 6, and one counter-overflow source. Channel 0 has its own interrupt request line. Channel 0 raises its flag on a set pulse and drops it when an acknowledge pulse reports that the CPU accepted the interrupt.

Channels 1 to 6 and the overflow source share a second request line and a read-only vector word. The vector word reports the highest-priority pending source as an even number. Software can add that number directly to its program counter to step into a jump table. Reading the vector word clears the flag of the reported source only. Any other pending source stays latched, and the next read returns it.

Each source has a flag set pulse and an enable bit. The vector word is combinational from the registered flags and the enables. A read strobe takes effect at the next rising clock edge.

Top module: `tmr_vec_irq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, every flag is clear, `vecWord` reads 0, and `shIrq` and `ch0Irq` are both low.
- R2: Bit i of `setPulse` and of `enMask` belongs to shared source i+1. Bits 0 to 5 are channels 1 to 6 and bit 6 is the overflow source. The vector codes are 2×channel for channels 1 to 6 (2, 4, 6, 8, 10, 12), 14 for overflow, and 0 for no pending source.
- R3: When several shared sources are pending and enabled, the vector reports the lowest channel number. Overflow has the lowest priority.
- R4: A source whose enable bit is 0 does not affect `vecWord` or `shIrq`. Its flag stays latched, and it appears in the vector as soon as its enable bit is set.
- R5: `shIrq` is high exactly when `vecWord` is non-zero.
- R6: A cycle with `vecRead` high clears, at the next rising edge, only the flag of the source that `vecWord` reported in that cycle. The next read returns the next pending source in priority order.
- R7: A read while `vecWord` is 0 leaves every flag unchanged.
- R8: If a set pulse and the read-clear hit the same source in the same cycle, the set wins and that source stays pending.
- R9: `ch0Irq` equals the channel 0 flag ANDed with `ch0En`. It is independent of the shared sources and of `vecRead`.
- R10: `ch0Ack` clears the channel 0 flag at the next rising edge, unless `ch0Set` is high in the same cycle, in which case the flag stays set.
- R11: A set pulse first shows on `vecWord` after the next rising edge. `vecWord` does not change in a cycle without a set pulse, a read, or a change of `enMask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| setPulse | input | 7 | Per-source flag set pulses for the shared sources |
| enMask | input | 7 | Per-source enables for the shared sources |
| ch0Set | input | 1 | Flag set pulse for channel 0 |
| ch0En | input | 1 | Interrupt enable for channel 0 |
| ch0Ack | input | 1 | One-cycle interrupt acceptance for channel 0 |
| vecRead | input | 1 | Bus read strobe of the vector word |
| vecWord | output | 16 | Even jump-table offset of the highest-priority pending source |
| shIrq | output | 1 | Shared interrupt request |
| ch0Irq | output | 1 | Channel 0 interrupt request |

## Verification
The assertions assume synchronous inputs that are stable across each rising edge. They also assume that `enMask` changes are not checked in the cycle they occur: several properties hold only when `enMask` did not change. The bench drives every input on the falling edge and keeps `enMask` fixed for long stretches. It also drives phases in which only one set pulse is active, so the set-wins-over-clear case can be isolated. Random traffic keeps set pulses sparse so that read sequences drain the flags.

// File: rtl/tmr_vec_pkg.sv
package tmr_vec_pkg;
  parameter int unsigned SHARED_SRC = 7;
  localparam int unsigned CODE_W = $clog2(2 * SHARED_SRC + 1);

  typedef struct packed {
    logic [SHARED_SRC-1:0] clrShared;
    logic                  clrCh0;
  } clr_strobe_t;
endpackage

// File: rtl/tmr_vec_flags.sv
module tmr_vec_flags
  import tmr_vec_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [SHARED_SRC-1:0] setPulse,
  input  logic                  ch0Set,
  input  clr_strobe_t           strb,
  output logic [SHARED_SRC-1:0] flags,
  output logic                  ch0Flag
);
  // set has priority over clear for every source
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags   <= '0;
      ch0Flag <= 1'b0;
    end else begin
      flags   <= (flags & ~strb.clrShared) | setPulse;
      ch0Flag <= (ch0Flag & ~strb.clrCh0) | ch0Set;
    end
  end
endmodule

// File: rtl/tmr_vec_ctrl.sv
module tmr_vec_ctrl
  import tmr_vec_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic [SHARED_SRC-1:0] flags,
  input  logic [SHARED_SRC-1:0] enMask,
  input  logic                  ch0Flag,
  input  logic                  ch0En,
  input  logic                  ch0Ack,
  input  logic                  vecRead,
  output logic [DATA_W-1:0]     vecWord,
  output logic                  shIrq,
  output logic                  ch0Irq,
  output clr_strobe_t           strb
);
  logic [SHARED_SRC-1:0] active;
  logic [SHARED_SRC-1:0] winHot;
  logic [CODE_W-1:0]     code;

  assign active = flags & enMask;

  // one-hot winner: lowest index has highest priority
  genvar g;
  generate
    for (g = 0; g < SHARED_SRC; g++) begin : g_pri
      if (g == 0) begin : g_first
        assign winHot[g] = active[g];
      end else begin : g_rest
        assign winHot[g] = active[g] & ~(|active[g-1:0]);
      end
    end
  endgenerate

  always_comb begin
    code = '0;
    for (int i = 0; i < SHARED_SRC; i++) begin
      if (winHot[i]) code = code | CODE_W'(2 * (i + 1));
    end
  end

  assign vecWord        = {{(DATA_W-CODE_W){1'b0}}, code};
  assign shIrq          = |active;
  assign ch0Irq         = ch0Flag & ch0En;
  assign strb.clrShared = vecRead ? winHot : '0;
  assign strb.clrCh0    = ch0Ack;
endmodule

// File: rtl/tmr_vec_irq.sv
module tmr_vec_irq
  import tmr_vec_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [SHARED_SRC-1:0] setPulse,
  input  logic [SHARED_SRC-1:0] enMask,
  input  logic                  ch0Set,
  input  logic                  ch0En,
  input  logic                  ch0Ack,
  input  logic                  vecRead,
  output logic [DATA_W-1:0]     vecWord,
  output logic                  shIrq,
  output logic                  ch0Irq
);
  clr_strobe_t           strb;
  logic [SHARED_SRC-1:0] flags;
  logic                  ch0Flag;

  tmr_vec_flags u_flags (
    .clk(clk), .rst_n(rst_n), .setPulse(setPulse), .ch0Set(ch0Set),
    .strb(strb), .flags(flags), .ch0Flag(ch0Flag)
  );

  tmr_vec_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .flags(flags), .enMask(enMask), .ch0Flag(ch0Flag), .ch0En(ch0En),
    .ch0Ack(ch0Ack), .vecRead(vecRead), .vecWord(vecWord),
    .shIrq(shIrq), .ch0Irq(ch0Irq), .strb(strb)
  );
endmodule

// File: rtl/tmr_vec_chk.sv
module tmr_vec_chk
  import tmr_vec_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [SHARED_SRC-1:0] setPulse,
  input logic [SHARED_SRC-1:0] enMask,
  input logic                  ch0Set,
  input logic                  ch0En,
  input logic                  ch0Ack,
  input logic                  vecRead,
  input logic [DATA_W-1:0]     vecWord,
  input logic                  shIrq,
  input logic                  ch0Irq
);
  logic reportedSet;
  always_comb begin
    reportedSet = 1'b0;
    for (int i = 0; i < SHARED_SRC; i++) begin
      if (vecWord == DATA_W'(2 * (i + 1)) && setPulse[i]) reportedSet = 1'b1;
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (vecWord == '0 && !shIrq && !ch0Irq));

  assert_vec_even_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (vecWord[0] == 1'b0 && vecWord <= DATA_W'(2 * SHARED_SRC)));

  assert_shirq_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
    shIrq == (vecWord != '0));

  assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vecRead && vecWord != '0 && !reportedSet) |=> (vecWord != $past(vecWord)));

  assert_lower_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vecRead && vecWord != '0 && setPulse == '0) |=>
      (!$stable(enMask) || vecWord == '0 || vecWord > $past(vecWord)));

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (vecRead && reportedSet && $countones(setPulse) == 1) |=>
      (!$stable(enMask) || vecWord == $past(vecWord)));

  assert_idle_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!vecRead && setPulse == '0) |=> (!$stable(enMask) || $stable(vecWord)));

  assert_ch0_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ch0Ack && !ch0Set) |=> !ch0Irq);

  assert_ch0_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ch0Set && ch0En) |=> (!ch0En || ch0Irq));
endmodule

bind tmr_vec_irq tmr_vec_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .setPulse(setPulse), .enMask(enMask),
  .ch0Set(ch0Set), .ch0En(ch0En), .ch0Ack(ch0Ack), .vecRead(vecRead),
  .vecWord(vecWord), .shIrq(shIrq), .ch0Irq(ch0Irq)
);

// File: tb/test_tmr_vec_irq.sv
`timescale 1ns/1ps
module test_tmr_vec_irq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  setPulse = '0;
  logic [6:0]  enMask = '0;
  logic        ch0Set = 1'b0, ch0En = 1'b0, ch0Ack = 1'b0, vecRead = 1'b0;
  logic [15:0] vecWord;
  logic        shIrq, ch0Irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit refFlag[7];
  bit refCh0;

  always #5 clk = ~clk;

  tmr_vec_irq i_tmr_vec_irq (
    .clk(clk), .rst_n(rst_n), .setPulse(setPulse), .enMask(enMask),
    .ch0Set(ch0Set), .ch0En(ch0En), .ch0Ack(ch0Ack), .vecRead(vecRead),
    .vecWord(vecWord), .shIrq(shIrq), .ch0Irq(ch0Irq)
  );

  function automatic int modelVec();
    for (int i = 0; i < 7; i++) if (refFlag[i] && enMask[i]) return 2 * (i + 1);
    return 0;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // called at a falling edge; compares outputs, then advances one cycle
  task automatic step(input logic [6:0] s, input logic [6:0] en, input logic rd,
                      input logic c0s, input logic c0e, input logic c0a, input string tag);
    int ev;
    setPulse = s; enMask = en; vecRead = rd; ch0Set = c0s; ch0En = c0e; ch0Ack = c0a;
    #1;
    ev = modelVec();
    check({tag, " vec (R2 R3 R4)"}, int'(vecWord), ev);
    check({tag, " shIrq (R5)"}, int'(shIrq), int'(ev != 0));
    check({tag, " ch0Irq (R9)"}, int'(ch0Irq), int'(refCh0 && c0e));
    @(posedge clk);
    for (int i = 0; i < 7; i++) begin
      if (rd && ev == 2 * (i + 1)) refFlag[i] = 0;
      if (s[i]) refFlag[i] = 1;
    end
    if (c0a) refCh0 = 0;
    if (c0s) refCh0 = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 7; i++) refFlag[i] = 0;
    refCh0 = 0;
    repeat (3) @(negedge clk);
    // R1: reset state while reset held, with pulses applied
    setPulse = 7'h7F; ch0Set = 1; enMask = 7'h7F; ch0En = 1;
    @(negedge clk);
    check("R1 vec in reset", int'(vecWord), 0);
    check("R1 shIrq in reset", int'(shIrq), 0);
    check("R1 ch0Irq in reset", int'(ch0Irq), 0);
    setPulse = '0; ch0Set = 0;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    step(7'h00, 7'h7F, 0, 0, 1, 0, "R1 first cycle");

    // R2: each source alone, then cleared by a read (R6); R11 needs a cycle to show
    for (int k = 0; k < 7; k++) begin
      step(7'(1 << k), 7'h7F, 0, 0, 0, 0, "R11 set");
      check("R2 code", int'(vecWord), 2 * (k + 1));
      step(7'h00, 7'h7F, 1, 0, 0, 0, "R6 read");
      step(7'h00, 7'h7F, 0, 0, 0, 0, "R6 after");
    end

    // R3/R6: all pending, repeated reads walk 2..14 then 0
    step(7'h7F, 7'h7F, 0, 0, 0, 0, "R3 setall");
    for (int k = 0; k < 8; k++) step(7'h00, 7'h7F, 1, 0, 0, 0, "R3 walk");

    // R4: disabled source latched but hidden, then appears on enable
    step(7'h02, 7'h7D, 0, 0, 0, 0, "R4 set masked");
    step(7'h00, 7'h7D, 1, 0, 0, 0, "R4 hidden read");
    step(7'h00, 7'h7F, 0, 0, 0, 0, "R4 enabled");
    check("R4 reappears", int'(vecWord), 4);
    step(7'h00, 7'h7F, 1, 0, 0, 0, "R4 clear");

    // R7: read with nothing reported while a disabled flag is held
    step(7'h40, 7'h3F, 0, 0, 0, 0, "R7 prep");
    step(7'h00, 7'h3F, 1, 0, 0, 0, "R7 idle read");
    step(7'h00, 7'h7F, 0, 0, 0, 0, "R7 flag kept");
    check("R7 overflow still held", int'(vecWord), 14);
    step(7'h00, 7'h7F, 1, 0, 0, 0, "R7 clear");

    // R8: set and read-clear of the same source collide
    step(7'h04, 7'h7F, 0, 0, 0, 0, "R8 prep");
    step(7'h04, 7'h7F, 1, 0, 0, 0, "R8 collide");
    step(7'h00, 7'h7F, 0, 0, 0, 0, "R8 after");
    check("R8 set wins", int'(vecWord), 6);
    step(7'h00, 7'h7F, 1, 0, 0, 0, "R8 clear");

    // R9/R10: channel 0 path
    step(7'h00, 7'h7F, 0, 1, 0, 0, "R9 set disabled");
    step(7'h00, 7'h7F, 1, 0, 1, 0, "R9 enabled");
    check("R9 ch0Irq", int'(ch0Irq), 1);
    check("R9 shared idle", int'(shIrq), 0);
    step(7'h00, 7'h7F, 0, 1, 1, 1, "R10 ack with set");
    step(7'h00, 7'h7F, 0, 0, 1, 1, "R10 ack");
    step(7'h00, 7'h7F, 0, 0, 1, 0, "R10 after ack");
    check("R10 cleared", int'(ch0Irq), 0);

    // random traffic, model compared every cycle
    for (int n = 0; n < 600; n++) begin
      logic [6:0] s;
      logic [6:0] en;
      s  = (($urandom % 4) == 0) ? 7'(1 << ($urandom % 7)) : 7'h00;
      en = (n < 300) ? 7'h7F : 7'h5B;
      step(s, en, 1'($urandom % 2), 1'(($urandom % 8) == 0), 1'b1,
           1'(($urandom % 6) == 0), "R6 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule